// File: doc/BRIEF.md
# SCSI Adapter Bus-Master DMA Engine

This block is the 32-bit bus-master DMA channel that sits next to a SCSI protocol core on a host adapter. Software programs a start count, a start address and a start descriptor address, then issues a start command through the command register. The start command copies those values into working registers and enables the channel. The SCSI core then asks for bursts. The engine caps each burst at the remaining working count and issues it on a valid/ready memory port at the working address. After each burst it advances the working address and reduces the working count.

The status register records done, error and abort, and shows the live SCSI core interrupt in bit 4. An external mode input picks how software clears the sticky bits. In one mode, writing a 1 to a bit clears it. In the other mode, reading the status register clears the bits. An abort command sends a one-cycle cancel pulse to the SCSI core. A completion signal from the core forces the transfer to its finished state.

Top module: `scsi_dma_engine`

## Requirements
- R1: After reset, the registers read at word offsets 0..7 as follows: command 0, start count 0, start address 0, working count 0, working address 0xFFFFFFFF, status 0, start descriptor 0, working descriptor 0xFFFFFFFD. xfer_en_o is 0.
- R2: The command (offset 0), start count (1), start address (2) and start descriptor (6) registers read back what was written. Writes to offsets 3, 4 and 7 leave those registers unchanged.
- R3: A command write with bits [1:0]=3 (start) does all of the following:
  - copies offset 1 into offset 3, offset 2 into offset 4, and offset 6 into offset 7;
  - clears status bits [5:0];
  - sets xfer_en_o.
  A command with bits [1:0]=0 (idle) clears xfer_en_o.
- R4: A command with bits [1:0]=2 (abort) raises cancel_o for exactly one cycle and sets status bit 2. A command with bits [1:0]=1 (blast) changes neither xfer_en_o nor cancel_o.
- R5: An accepted burst has these properties:
  - it drives mem_addr_o equal to the working address;
  - it drives mem_len_o equal to min(burst_len_i, working count);
  - mem_write_o equals command bit 7;
  - on the grant, the working count drops by that length and the working address rises by it.
  burst_ack_o then pulses with burst_xfer_len_o holding the length.
- R6: Status bit 3 (done) is set when a burst brings the working count to zero.
- R7: A burst whose burst_dir_i differs from command bit 7 (1 = device to memory) moves no data. mem_valid_o stays low, burst_ack_o pulses with length 0, the working count and address stay as they were, and status bit 1 (error) is set.
- R8: With stat_w1c_i=1, a write to status offset 5 clears each of bits 1, 2 and 3 whose written bit is 1, and reads do not clear anything. With stat_w1c_i=0, writes to status change nothing.
- R9: With stat_w1c_i=0, a status read returns the current value and then clears bits 1, 2 and 3.
- R10: Status bit 4 reads as core_irq_i and is never stored.
- R11: A pulse on core_done_i sets the working count to 0 and sets status bit 3.
- R12: While mem_valid_o is high and mem_ready_i is low, mem_valid_o, mem_addr_o and mem_len_o hold steady.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on status) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| stat_w1c_i | input | 1 | Status clear mode: 1 write-one-to-clear, 0 clear-after-read |
| core_irq_i | input | 1 | SCSI core interrupt level |
| core_done_i | input | 1 | SCSI core command-complete pulse |
| xfer_en_o | output | 1 | Transfer enabled toward the SCSI core |
| cancel_o | output | 1 | One-cycle cancel request toward the SCSI core |
| burst_req_i | input | 1 | Burst request pulse from the SCSI core |
| burst_len_i | input | 16 | Requested burst length in bytes |
| burst_dir_i | input | 1 | Requested direction, 1 = device to memory |
| burst_ack_o | output | 1 | Burst finished or dropped |
| burst_xfer_len_o | output | 16 | Bytes moved by the acknowledged burst |
| mem_valid_o | output | 1 | Memory burst request valid |
| mem_ready_i | input | 1 | Memory burst grant |
| mem_addr_o | output | 32 | Burst start address |
| mem_len_o | output | 16 | Burst length in bytes |
| mem_write_o | output | 1 | 1 = write to memory |

## Verification
The burst path is exercised with three kinds of request:
- A request shorter than the remaining count shows that the length is passed through and that both working registers advance.
- A request longer than the remaining count shows the cap, and shows done being set as the count reaches zero.
- A request in the wrong direction must produce an error flag and a zero-length acknowledge, with no memory cycle.

A grant held back for several cycles separates a port that holds its request steady from one that changes it. Sticky status bits are raised by abort, by a dropped burst and by core completion, then cleared in each mode, so that write-one-to-clear can be told apart from clear-after-read.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_CMD   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_SCNT  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_SADDR = 3'd2;
  localparam logic [REG_AW-1:0] OFS_WCNT  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_WADDR = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_SDESC = 3'd6;
  localparam logic [REG_AW-1:0] OFS_WDESC = 3'd7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int unsigned CMD_W     = 8;
  localparam int unsigned CMD_DIR   = 7;
  localparam int unsigned STAT_W    = 6;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_ABT    = 2;
  localparam int unsigned ST_DONE   = 3;
  localparam int unsigned ST_IRQ    = 4;
  localparam logic [STAT_W-1:0] STICKY_MASK = 6'b00_1110;
endpackage

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              w1c_mode_i,
  input  logic              core_irq_i,
  input  logic              core_done_i,
  input  logic              commit_i,
  input  logic [LEN_W-1:0]  commit_len_i,
  input  logic              drop_i,
  output logic              xfer_en_o,
  output logic              cancel_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] scnt_o,
  output logic [DATA_W-1:0] wcnt_o,
  output logic [DATA_W-1:0] waddr_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] WADDR_RST = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] WDESC_RST = ~DATA_W'(2);

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] scnt_q, saddr_q, sdesc_q, wcnt_q, waddr_q, wdesc_q;
  logic [STAT_W-1:0] stat_q, stat_nxt;
  logic              en_q, cancel_q;

  dma_op_e     op;
  logic        cmd_wr, is_start, is_idle, is_abort, stat_wr, stat_rd;
  logic [DATA_W-1:0] len_ext;

  assign op       = dma_op_e'(wdata_i[1:0]);
  assign cmd_wr   = wr_i && (addr_i == OFS_CMD);
  assign is_start = cmd_wr && (op == OP_START);
  assign is_idle  = cmd_wr && (op == OP_IDLE);
  assign is_abort = cmd_wr && (op == OP_ABORT);
  assign stat_wr  = wr_i && (addr_i == OFS_STAT);
  assign stat_rd  = rd_i && (addr_i == OFS_STAT);
  assign len_ext  = DATA_W'(commit_len_i);

  always_comb begin
    stat_nxt = stat_q;
    if (stat_rd && !w1c_mode_i) stat_nxt = stat_nxt & ~STICKY_MASK;
    if (stat_wr && w1c_mode_i)  stat_nxt = stat_nxt & ~(wdata_i[STAT_W-1:0] & STICKY_MASK);
    if (is_start) stat_nxt = '0;
    if (drop_i)   stat_nxt[ST_ERR] = 1'b1;
    if (is_abort) stat_nxt[ST_ABT] = 1'b1;
    if (commit_i && !is_start && (len_ext == wcnt_q)) stat_nxt[ST_DONE] = 1'b1;
    if (core_done_i) stat_nxt[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      scnt_q   <= '0;
      saddr_q  <= '0;
      sdesc_q  <= '0;
      wcnt_q   <= '0;
      waddr_q  <= WADDR_RST;
      wdesc_q  <= WDESC_RST;
      stat_q   <= '0;
      en_q     <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cancel_q <= is_abort;
      stat_q   <= stat_nxt;
      if (wr_i) begin
        unique case (addr_i)
          OFS_CMD:   cmd_q   <= wdata_i[CMD_W-1:0];
          OFS_SCNT:  scnt_q  <= wdata_i;
          OFS_SADDR: saddr_q <= wdata_i;
          OFS_SDESC: sdesc_q <= wdata_i;
          default: ;
        endcase
      end
      if (is_start)  en_q <= 1'b1;
      else if (is_idle) en_q <= 1'b0;
      if (is_start) begin
        wcnt_q  <= scnt_q;
        waddr_q <= saddr_q;
        wdesc_q <= sdesc_q;
      end else begin
        if (core_done_i)   wcnt_q <= '0;
        else if (commit_i) wcnt_q <= wcnt_q - len_ext;
        if (commit_i)      waddr_q <= waddr_q + len_ext;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CMD:   rdata_o = DATA_W'(cmd_q);
      OFS_SCNT:  rdata_o = scnt_q;
      OFS_SADDR: rdata_o = saddr_q;
      OFS_WCNT:  rdata_o = wcnt_q;
      OFS_WADDR: rdata_o = waddr_q;
      OFS_STAT:  rdata_o = DATA_W'(stat_q | (STAT_W'(core_irq_i) << ST_IRQ));
      OFS_SDESC: rdata_o = sdesc_q;
      default:   rdata_o = wdesc_q;
    endcase
  end

  assign xfer_en_o = en_q;
  assign cancel_o  = cancel_q;
  assign cmd_o     = cmd_q;
  assign scnt_o    = scnt_q;
  assign wcnt_o    = wcnt_q;
  assign waddr_o   = waddr_q;
  assign stat_o    = stat_q;
endmodule

// File: rtl/scsi_dma_burst.sv
module scsi_dma_burst #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dir_i,
  input  logic              en_i,
  input  logic              cmd_dir_i,
  input  logic [DATA_W-1:0] wcnt_i,
  input  logic [DATA_W-1:0] waddr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic              commit_o,
  output logic [LEN_W-1:0]  commit_len_o,
  output logic              drop_o,
  output logic              ack_o,
  output logic [LEN_W-1:0]  xfer_len_o
);
  typedef enum logic {S_IDLE, S_BUSY} bst_state_e;

  bst_state_e        state_q;
  logic [DATA_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, xlen_q, cap;
  logic              ack_q, take, skip;

  // Cap the request at the remaining count
  assign cap  = (DATA_W'(len_i) < wcnt_i) ? len_i : wcnt_i[LEN_W-1:0];
  assign take = (state_q == S_IDLE) && req_i && en_i;
  assign drop_o = take && (dir_i != cmd_dir_i);
  assign skip   = take && (drop_o || (cap == '0));
  assign commit_o = (state_q == S_BUSY) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      xlen_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (skip) begin
        ack_q  <= 1'b1;
        xlen_q <= '0;
      end else if (take) begin
        state_q <= S_BUSY;
        addr_q  <= waddr_i;
        len_q   <= cap;
      end else if (commit_o) begin
        state_q <= S_IDLE;
        ack_q   <= 1'b1;
        xlen_q  <= len_q;
      end
    end
  end

  assign mem_valid_o  = (state_q == S_BUSY);
  assign mem_addr_o   = addr_q;
  assign mem_len_o    = len_q;
  assign commit_len_o = len_q;
  assign ack_o        = ack_q;
  assign xfer_len_o   = xlen_q;
endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
  import scsi_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              stat_w1c_i,
  input  logic              core_irq_i,
  input  logic              core_done_i,
  output logic              xfer_en_o,
  output logic              cancel_o,
  input  logic              burst_req_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic              burst_dir_i,
  output logic              burst_ack_o,
  output logic [LEN_W-1:0]  burst_xfer_len_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic              mem_write_o
);
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] scnt, wcnt, waddr;
  logic [STAT_W-1:0] stat;
  logic              commit, drop;
  logic [LEN_W-1:0]  commit_len;

  scsi_dma_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .rd_i         (reg_rd_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .w1c_mode_i   (stat_w1c_i),
    .core_irq_i   (core_irq_i),
    .core_done_i  (core_done_i),
    .commit_i     (commit),
    .commit_len_i (commit_len),
    .drop_i       (drop),
    .xfer_en_o    (xfer_en_o),
    .cancel_o     (cancel_o),
    .cmd_o        (cmd),
    .scnt_o       (scnt),
    .wcnt_o       (wcnt),
    .waddr_o      (waddr),
    .stat_o       (stat)
  );

  scsi_dma_burst #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (burst_req_i),
    .len_i        (burst_len_i),
    .dir_i        (burst_dir_i),
    .en_i         (xfer_en_o),
    .cmd_dir_i    (cmd[CMD_DIR]),
    .wcnt_i       (wcnt),
    .waddr_i      (waddr),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .drop_o       (drop),
    .ack_o        (burst_ack_o),
    .xfer_len_o   (burst_xfer_len_o)
  );

  assign mem_write_o = cmd[CMD_DIR];
endmodule

// File: rtl/scsi_dma_chk.sv
module scsi_dma_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              core_done_i,
  input logic              xfer_en_o,
  input logic              cancel_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0]  mem_len_o,
  input logic [DATA_W-1:0] scnt,
  input logic [DATA_W-1:0] wcnt,
  input logic [DATA_W-1:0] waddr,
  input logic [5:0]        stat
);
  logic start_wr;
  assign start_wr = reg_wr_i && (reg_addr_i == 3'd0) && (reg_wdata_i[1:0] == 2'd3);

  a_r12_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_len_o));

  a_r4_cancel_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> !cancel_o);

  a_r11_core_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_i && !start_wr |=> (wcnt == '0) && stat[3]);

  a_r3_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr && !core_done_i |=> (wcnt == $past(scnt)) && xfer_en_o && (stat == '0));

  a_r5_burst_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_valid_o) |-> (mem_addr_o == waddr) && (DATA_W'(mem_len_o) <= wcnt)
                           && (mem_len_o != '0));

  a_r6_done_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && (DATA_W'(mem_len_o) == wcnt) && !start_wr |=> stat[3]);
endmodule

bind scsi_dma_engine scsi_dma_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .core_done_i (core_done_i),
  .xfer_en_o   (xfer_en_o),
  .cancel_o    (cancel_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .scnt        (scnt),
  .wcnt        (wcnt),
  .waddr       (waddr),
  .stat        (stat)
);

// File: tb/sim_scsi_dma_engine.sv
`timescale 1ns/1ps
module sim_scsi_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        w1c = 1'b0, irq = 1'b0, cdone = 1'b0;
  logic        xfer_en, cancel;
  logic        breq = 1'b0, bdir = 1'b0, back;
  logic [15:0] blen = '0, bxlen, mlen;
  logic        mvalid, mready = 1'b0, mwrite;
  logic [31:0] maddr;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  scsi_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .stat_w1c_i(w1c), .core_irq_i(irq), .core_done_i(cdone),
    .xfer_en_o(xfer_en), .cancel_o(cancel),
    .burst_req_i(breq), .burst_len_i(blen), .burst_dir_i(bdir),
    .burst_ack_o(back), .burst_xfer_len_o(bxlen),
    .mem_valid_o(mvalid), .mem_ready_i(mready), .mem_addr_o(maddr),
    .mem_len_o(mlen), .mem_write_o(mwrite)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data from the scoreboard
  always @(negedge clk) begin
    #2;
    if (reg_rd && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    reg_rd = 1'b1;
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic burst(logic [15:0] len, logic dir, int delay,
                       logic exp_mem, logic [31:0] exp_addr, logic [15:0] exp_len, string tag);
    @(negedge clk);
    breq = 1'b1; blen = len; bdir = dir;
    @(negedge clk);
    breq = 1'b0;
    #1;
    if (exp_mem) begin
      chk({tag, " valid"}, 32'(mvalid), 32'd1);
      chk({tag, " addr"}, maddr, exp_addr);
      chk({tag, " len"}, 32'(mlen), 32'(exp_len));
      chk({tag, " write"}, 32'(mwrite), 32'(dir));
      for (int i = 0; i < delay; i++) begin
        @(negedge clk); #1;
        chk("R12 held valid", 32'(mvalid), 32'd1);
        chk("R12 held addr", maddr, exp_addr);
        chk("R12 held len", 32'(mlen), 32'(exp_len));
      end
      mready = 1'b1;
      @(negedge clk);
      mready = 1'b0;
      #1;
    end else begin
      chk({tag, " no valid"}, 32'(mvalid), 32'd0);
    end
    chk({tag, " ack"}, 32'(back), 32'd1);
    chk({tag, " xfer len"}, 32'(bxlen), 32'(exp_len));
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 xfer_en", 32'(xfer_en), 32'd0);
    rd(3'd0, 32'h0, "R1 cmd");
    rd(3'd1, 32'h0, "R1 scnt");
    rd(3'd2, 32'h0, "R1 saddr");
    rd(3'd3, 32'h0, "R1 wcnt");
    rd(3'd4, 32'hFFFF_FFFF, "R1 waddr");
    rd(3'd5, 32'h0, "R1 stat");
    rd(3'd6, 32'h0, "R1 sdesc");
    rd(3'd7, 32'hFFFF_FFFD, "R1 wdesc");
    // R2 writable and ignored offsets
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h8000);
    wr(3'd6, 32'h4000);
    wr(3'd3, 32'h5);
    wr(3'd4, 32'h6);
    wr(3'd7, 32'h7);
    rd(3'd1, 32'h100, "R2 scnt");
    rd(3'd2, 32'h8000, "R2 saddr");
    rd(3'd6, 32'h4000, "R2 sdesc");
    rd(3'd3, 32'h0, "R2 wcnt ignored");
    rd(3'd4, 32'hFFFF_FFFF, "R2 waddr ignored");
    rd(3'd7, 32'hFFFF_FFFD, "R2 wdesc ignored");
    // R3 start, device to memory
    wr(3'd0, 32'h83);
    chk("R3 enable", 32'(xfer_en), 32'd1);
    rd(3'd0, 32'h83, "R2 cmd");
    rd(3'd3, 32'h100, "R3 wcnt load");
    rd(3'd4, 32'h8000, "R3 waddr load");
    rd(3'd7, 32'h4000, "R3 wdesc load");
    // R5 short burst with delayed grant
    burst(16'h40, 1'b1, 3, 1'b1, 32'h8000, 16'h40, "R5 short");
    rd(3'd3, 32'hC0, "R5 wcnt after");
    rd(3'd4, 32'h8040, "R5 waddr after");
    rd(3'd5, 32'h0, "R6 not done yet");
    // R7 wrong direction
    burst(16'h10, 1'b0, 0, 1'b0, 32'h0, 16'h0, "R7 drop");
    rd(3'd3, 32'hC0, "R7 wcnt kept");
    rd(3'd4, 32'h8040, "R7 waddr kept");
    rd(3'd5, 32'h02, "R7 error set");
    rd(3'd5, 32'h00, "R9 cleared after read");
    // R5/R6 capped burst reaches zero
    burst(16'h200, 1'b1, 0, 1'b1, 32'h8040, 16'hC0, "R5 capped");
    rd(3'd3, 32'h0, "R6 wcnt zero");
    rd(3'd4, 32'h8100, "R5 waddr end");
    rd(3'd5, 32'h08, "R6 done");
    rd(3'd5, 32'h00, "R9 done cleared");
    // R10 live interrupt bit
    @(negedge clk); irq = 1'b1;
    rd(3'd5, 32'h10, "R10 irq shown");
    @(negedge clk); irq = 1'b0;
    rd(3'd5, 32'h00, "R10 irq not stored");
    // R4 blast has no effect
    wr(3'd0, 32'h81);
    chk("R4 blast cancel", 32'(cancel), 32'd0);
    chk("R4 blast enable", 32'(xfer_en), 32'd1);
    // R4/R8 abort in write-one-to-clear mode
    w1c = 1'b1;
    wr(3'd0, 32'h82);
    #1;
    chk("R4 cancel pulse", 32'(cancel), 32'd1);
    @(negedge clk); #1;
    chk("R4 cancel ends", 32'(cancel), 32'd0);
    rd(3'd5, 32'h04, "R4 abort flag");
    rd(3'd5, 32'h04, "R8 read keeps");
    wr(3'd5, 32'h0B);
    rd(3'd5, 32'h04, "R8 other bits kept");
    wr(3'd5, 32'h04);
    rd(3'd5, 32'h00, "R8 cleared by write");
    // R8 write ignored in read-clear mode
    wr(3'd0, 32'h82);
    w1c = 1'b0;
    wr(3'd5, 32'h04);
    rd(3'd5, 32'h04, "R8 write ignored");
    // R3 start clears sticky status (abort left set)
    w1c = 1'b1;
    wr(3'd0, 32'h82);
    wr(3'd0, 32'h83);
    rd(3'd5, 32'h00, "R3 status cleared");
    rd(3'd3, 32'h100, "R3 reload");
    // R11 core completion
    @(negedge clk); cdone = 1'b1;
    @(negedge clk); cdone = 1'b0;
    rd(3'd3, 32'h0, "R11 wcnt forced");
    rd(3'd5, 32'h08, "R11 done");
    // R3 idle disables
    wr(3'd0, 32'h80);
    chk("R3 idle disable", 32'(xfer_en), 32'd0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule